// File: doc/BRIEF.md
# Trace Message Serializer Port

This block streams debug trace messages out through a narrow auxiliary port. The port has a 12-bit data bus and a two-bit strobe. A message is a list of variable-length packets. Upstream logic offers a whole message at once: a packet count plus a bit length and a data word for each packet, under a valid/ready handshake. The block cuts each packet into beats of the chosen bus width, least significant bits first. It marks packet and message boundaries on the strobe so that a tool sampling on the rising clock edge can rebuild the stream.

A configuration input selects a 4-bit or a 12-bit bus for each message. A rising edge on an asynchronous event input queues a synchronization message, which goes out as soon as the current message has finished. A breakpoint input yields a one-cycle event output pulse. Until reset is released and the clock reports lock, bit 0 of the bus is held high.

Top module: `trace_msg_port`

## Requirements
- R1: During reset, and afterwards until `lock_i` is sampled high at a clock edge, `mdo` is 12'h001, `mseo` is 2'b11 and `msg_ready` is 0. Once locked, the idle bus shows `mdo`=0 with `mseo`=2'b11.
- R2: `wide_i`=0 selects 4-bit beats (`mdo[11:4]` held at 0) and `wide_i`=1 selects 12-bit beats. The value is sampled when the message is taken and holds for every beat of that message.
- R3: Beat b of a packet carries packet bits [b*W +: W]. Bits at or above the packet length are driven as 0. Every packet starts on a new beat.
- R4: The strobe is 2'b00 on ordinary beats, 2'b01 on the last beat of a packet that is not the final one, and 2'b11 on the final beat of a message and when idle. 2'b10 never appears. The first beat of a message is therefore the first non-11 strobe after idle.
- R5: A message holds 2 to MAX_PKTS packets, each 1 to PKT_DW bits long. `msg_ready` is high only when the port is locked, idle, past its gap and has no synchronization request pending. A message is taken at a clock edge where `msg_valid` and `msg_ready` are both high, and its first beat appears in the following cycle. `msg_ready` stays low until the message has been fully sent.
- R6: At least two idle beats (`mseo`=2'b11, `mdo`=0) follow the end of every message before the next message starts.
- R7: `evt_in` passes through two synchronizing flops, then rising-edge detection. Each rising edge requests one synchronization message. Holding the input high produces no further request, and edges that arrive while a request is still pending merge into that request.
- R8: A synchronization message has two packets: a 6-bit packet holding the code 8, then an 8-bit packet holding SYNC_TAG (default 8'hA5). It starts only after the message in progress has finished, and it takes precedence over an upstream message that is waiting.
- R9: `evt_out` is high for exactly one cycle, the cycle after a rising edge of `brk_in` is sampled. Holding `brk_in` high gives a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Message clock; outputs change only on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Clock-lock indication |
| wide_i | input | 1 | Bus width select: 0 = 4 bits, 1 = 12 bits |
| msg_valid | input | 1 | Upstream message offered |
| msg_ready | output | 1 | Port can take a message |
| msg_npkts | input | 3 | Number of packets in the message |
| msg_len | input | 24 | Packet lengths, 6 bits each, packet 0 in the low field |
| msg_data | input | 128 | Packet data, 32 bits each, packet 0 in the low word |
| evt_in | input | 1 | Asynchronous synchronization request (edge) |
| brk_in | input | 1 | Breakpoint indication |
| mdo | output | 12 | Message data bus |
| mseo | output | 2 | Message start/end strobe |
| evt_out | output | 1 | Event indication pulse |

## Verification
Two functions can meet in the same cycle. A synchronization request can mature while a long message is streaming, at the same time as the next upstream message is already offered. The bench provokes this by pulsing `evt_in` in the middle of a 32-beat message while holding `msg_valid` high with another message. It judges the outcome against a behavioural queue model: the sync beats must follow the end gap of the running message, and the waiting message must follow only after a second gap. A long high level on `evt_in` is also checked to yield exactly one synchronization message.

// File: rtl/trace_msg_port.sv
module trace_msg_port #(
  parameter int MAX_PKTS  = 4,
  parameter int PKT_DW    = 32,
  parameter int GAP_BEATS = 2,
  parameter logic [7:0] SYNC_TAG = 8'hA5,
  localparam int LEN_W = $clog2(PKT_DW + 1),
  localparam int CNT_W = $clog2(MAX_PKTS + 1),
  localparam int IDX_W = $clog2(MAX_PKTS),
  localparam int OFF_W = LEN_W + 1,
  localparam int GAP_W = $clog2(GAP_BEATS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lock_i,
  input  logic                       wide_i,
  input  logic                       msg_valid,
  output logic                       msg_ready,
  input  logic [CNT_W-1:0]           msg_npkts,
  input  logic [MAX_PKTS*LEN_W-1:0]  msg_len,
  input  logic [MAX_PKTS*PKT_DW-1:0] msg_data,
  input  logic                       evt_in,
  input  logic                       brk_in,
  output logic [11:0]                mdo,
  output logic [1:0]                 mseo,
  output logic                       evt_out
);

  logic              locked, busy, wcur, pend, brk_q;
  logic [2:0]        es;
  logic [CNT_W-1:0]  npk;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [GAP_W-1:0]  gcnt;
  logic [LEN_W-1:0]  pk_len [MAX_PKTS];
  logic [PKT_DW-1:0] pk_dat [MAX_PKTS];

  logic [LEN_W-1:0]  cur_len;
  logic [PKT_DW-1:0] cur_mask;
  logic [11:0]       beat;
  logic [OFF_W:0]    nxt;
  logic              pkt_end, msg_end, take_sync, sync_edge, can_go;

  assign cur_len   = pk_len[idx];
  assign cur_mask  = {PKT_DW{1'b1}} >> (PKT_DW - int'(cur_len));
  assign beat      = 12'((pk_dat[idx] & cur_mask) >> off);
  assign nxt       = {1'b0, off} + (wcur ? (OFF_W+1)'(12) : (OFF_W+1)'(4));
  assign pkt_end   = nxt >= (OFF_W+1)'(cur_len);
  assign msg_end   = pkt_end && (CNT_W'(idx) == npk - 1'b1);
  assign can_go    = locked && !busy && gcnt == '0;
  assign take_sync = can_go && pend;
  assign msg_ready = can_go && !pend;
  assign sync_edge = es[1] & ~es[2];

  assign mdo  = !locked ? 12'h001 :
                !busy   ? 12'h000 :
                wcur    ? beat : {8'h00, beat[3:0]};
  assign mseo = (!busy || msg_end) ? 2'b11 : (pkt_end ? 2'b01 : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      busy    <= 1'b0;
      wcur    <= 1'b0;
      pend    <= 1'b0;
      brk_q   <= 1'b0;
      evt_out <= 1'b0;
      es      <= '0;
      npk     <= '0;
      idx     <= '0;
      off     <= '0;
      gcnt    <= '0;
      for (int p = 0; p < MAX_PKTS; p++) begin
        pk_len[p] <= '0;
        pk_dat[p] <= '0;
      end
    end else begin
      if (lock_i) locked <= 1'b1;
      es      <= {es[1:0], evt_in};
      brk_q   <= brk_in;
      evt_out <= brk_in & ~brk_q;
      pend    <= (pend & ~take_sync) | sync_edge;
      if (busy) begin
        if (msg_end) begin
          busy <= 1'b0;
          gcnt <= GAP_W'(GAP_BEATS - 1);
        end else if (pkt_end) begin
          idx <= idx + 1'b1;
          off <= '0;
        end else begin
          off <= nxt[OFF_W-1:0];
        end
      end else if (gcnt != '0) begin
        gcnt <= gcnt - 1'b1;
      end else if (take_sync) begin
        busy      <= 1'b1;
        wcur      <= wide_i;
        idx       <= '0;
        off       <= '0;
        npk       <= CNT_W'(2);
        pk_len[0] <= LEN_W'(6);
        pk_dat[0] <= PKT_DW'(8);
        pk_len[1] <= LEN_W'(8);
        pk_dat[1] <= PKT_DW'(SYNC_TAG);
      end else if (msg_valid && msg_ready) begin
        busy <= 1'b1;
        wcur <= wide_i;
        idx  <= '0;
        off  <= '0;
        npk  <= msg_npkts;
        for (int p = 0; p < MAX_PKTS; p++) begin
          pk_len[p] <= msg_len[p*LEN_W +: LEN_W];
          pk_dat[p] <= msg_data[p*PKT_DW +: PKT_DW];
        end
      end
    end
  end

  // R5
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> mseo != 2'b11);

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> (mseo == 2'b11 && mdo == 12'h000));

  // R6
  end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mseo) != 2'b11 && mseo == 2'b11) |=> (mseo == 2'b11 && !msg_ready));

  // R2
  narrow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && !wide_i |=> mdo[11:4] == 8'h00);

  // R9
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |=> !evt_out);

endmodule

// File: tb/trace_msg_port_tb.sv
module trace_msg_port_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lock_i = 1'b0, wide_i = 1'b0, msg_valid = 1'b0;
  logic         evt_in = 1'b0, brk_in = 1'b0;
  logic [2:0]   msg_npkts = '0;
  logic [23:0]  msg_len = '0;
  logic [127:0] msg_data = '0;
  logic         msg_ready, evt_out;
  logic [11:0]  mdo;
  logic [1:0]   mseo;

  trace_msg_port dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .wide_i(wide_i),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_npkts(msg_npkts),
    .msg_len(msg_len), .msg_data(msg_data), .evt_in(evt_in), .brk_in(brk_in),
    .mdo(mdo), .mseo(mseo), .evt_out(evt_out));

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  bit started = 0, done = 0;

  typedef struct packed { logic [11:0] d; logic [1:0] s; } beat_t;
  beat_t q[$];
  bit m_locked = 0, m_pend = 0, s1 = 0, s2 = 0, s3 = 0, brk_q = 0, m_evt = 0;
  int m_gap = 0, n_starts_exp = 0, n_starts_obs = 0, n_sync_exp = 0;
  int m_len[4];
  logic [31:0] m_dat[4];
  logic [1:0] prev_mseo = 2'b11;

  function automatic void push_msg(int n, bit wide);
    int w = wide ? 12 : 4;
    for (int p = 0; p < n; p++) begin
      int nb = (m_len[p] + w - 1) / w;
      logic [31:0] v = (m_len[p] >= 32) ? m_dat[p] : (m_dat[p] & ((32'h1 << m_len[p]) - 1));
      for (int b = 0; b < nb; b++) begin
        beat_t bt;
        bt.d = 12'(v >> (b * w)) & (wide ? 12'hfff : 12'h00f);
        bt.s = (b == nb - 1) ? ((p == n - 1) ? 2'b11 : 2'b01) : 2'b00;
        q.push_back(bt);
      end
    end
    n_starts_exp++;
  endfunction

  always @(posedge clk) begin
    bit rdy, tsync, edge_s;
    started = 1;
    rdy    = m_locked && q.size() == 0 && m_gap == 0 && !m_pend;
    tsync  = m_locked && q.size() == 0 && m_gap == 0 && m_pend;
    edge_s = s2 && !s3;
    if (!rst_n) begin
      m_locked = 0; m_pend = 0; s1 = 0; s2 = 0; s3 = 0; brk_q = 0; m_evt = 0;
      m_gap = 0; q.delete();
    end else begin
      if (q.size() != 0) begin
        void'(q.pop_front());
        if (q.size() == 0) m_gap = 1;
      end else if (m_gap != 0) begin
        m_gap--;
      end else if (tsync) begin
        m_len[0] = 6; m_dat[0] = 32'd8; m_len[1] = 8; m_dat[1] = 32'hA5;
        push_msg(2, wide_i);
        n_sync_exp++;
      end else if (rdy && msg_valid) begin
        for (int p = 0; p < 4; p++) begin
          m_len[p] = int'(msg_len[p*6 +: 6]);
          m_dat[p] = msg_data[p*32 +: 32];
        end
        push_msg(int'(msg_npkts), wide_i);
      end
      m_pend = (m_pend && !tsync) || edge_s;
      s3 = s2; s2 = s1; s1 = evt_in;
      m_evt = brk_in && !brk_q; brk_q = brk_in;
      if (lock_i) m_locked = 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    logic [11:0] ed;
    logic [1:0]  es;
    bit er;
    ed = !m_locked ? 12'h001 : (q.size() != 0 ? q[0].d : 12'h000);
    es = q.size() != 0 ? q[0].s : 2'b11;
    er = m_locked && q.size() == 0 && m_gap == 0 && !m_pend;
    chk(mdo === ed, "R1/R2/R3/R8 mdo", int'(mdo), int'(ed));
    chk(mseo === es, "R4/R6 mseo", int'(mseo), int'(es));
    chk(msg_ready === er, "R5/R6 msg_ready", int'(msg_ready), int'(er));
    chk(evt_out === m_evt, "R9 evt_out", int'(evt_out), int'(m_evt));
    if (prev_mseo == 2'b11 && mseo != 2'b11) n_starts_obs++;
    prev_mseo = mseo;
  end

  task automatic set_pkt(int p, int len, logic [31:0] d);
    msg_len[p*6 +: 6]    = 6'(len);
    msg_data[p*32 +: 32] = d;
  endtask

  task automatic send();
    msg_valid = 1'b1;
    do @(negedge clk); while (!msg_ready);
    @(posedge clk); #1;
    msg_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);   // R1: still unlocked
    #1 lock_i = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R2 R3 narrow, junk above length
    wide_i = 1'b0; msg_npkts = 3'd2;
    set_pkt(0, 7, 32'hFFFF_FFAB); set_pkt(1, 32, 32'h1234_5678);
    send();
    // R2 R3 R4 wide, three packets, back to back (R6 gap)
    wide_i = 1'b1; msg_npkts = 3'd3;
    set_pkt(0, 12, 32'h0000_0ABC); set_pkt(1, 13, 32'hFFFF_1FFF); set_pkt(2, 1, 32'hFFFF_FFFF);
    send();
    msg_npkts = 3'd4;
    set_pkt(0, 5, 32'hDEAD_BEEF); set_pkt(1, 24, 32'h00C0_FFEE);
    set_pkt(2, 31, 32'hF0F0_F0F0); set_pkt(3, 9, 32'h0000_03FF);
    send();
    wide_i = 1'b0;   // width change after accept must not affect message (R2)

    // R7 R8: sync request during a long message while the next one waits
    msg_npkts = 3'd4;
    for (int p = 0; p < 4; p++) set_pkt(p, 32, 32'h1357_9BDF + p);
    send();
    fork
      begin
        wide_i = 1'b1; msg_npkts = 3'd2;
        set_pkt(0, 3, 32'h5); set_pkt(1, 20, 32'hABCDE);
        send();
      end
      begin
        repeat (3) @(posedge clk); #1 evt_in = 1'b1;
        @(posedge clk); #1 evt_in = 1'b0;
      end
    join
    repeat (30) @(posedge clk); #1;

    // R7: held level gives one sync only; R9: breakpoint pulses
    evt_in = 1'b1; brk_in = 1'b1;
    repeat (40) @(posedge clk); #1;
    evt_in = 1'b0; brk_in = 1'b0;
    @(posedge clk); #1 brk_in = 1'b1;
    @(posedge clk); #1 brk_in = 1'b0;
    @(posedge clk); #1 brk_in = 1'b1;
    @(posedge clk); #1 brk_in = 1'b0;

    // R8: sync request and upstream valid offered together at idle
    wide_i = 1'b0; msg_npkts = 3'd2;
    set_pkt(0, 8, 32'h96); set_pkt(1, 4, 32'h3);
    evt_in = 1'b1;
    send();
    evt_in = 1'b0;
    repeat (60) @(posedge clk); #1;

    // R7: message and sync counts seen at the port
    chk(n_starts_obs == n_starts_exp, "R7 message count", n_starts_obs, n_starts_exp);
    chk(n_sync_exp == 3, "R7 sync count", n_sync_exp, 3);
    finish_run();
  end
endmodule